// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block paces refresh for a simple DRAM controller. A prescaled up-counter runs from zero up to a programmable limit. When the counter reaches the limit, it returns to zero, latches a sticky match flag and pulses a refresh request for one clock. The request goes to a separate RAS/CAS sequencer. Software sets up the prescaler, the limit and the refresh enable through a small register port. Software polls and clears the flag, for example to count out the DRAM power-up initialisation time.

The block treats three power-down conditions differently:

- **Sleep** changes nothing.
- **Software standby** clears and holds the counter but keeps the configuration.
- **Hardware standby** stops the block and returns every register to its reset value.

After reset or after either standby ends, the first match raises the flag but issues no refresh.

Top module: `refresh_timer`

## Requirements
- R1: After reset the register reads are: control 0x00, status 0x00, counter 0x00, limit 0xFF. The refresh request is low.
- R2: The register map is as follows. Address 0 is control, with bit 0 as the refresh enable. Address 1 is status, with bit 7 as the match flag and bits 5:3 as the clock select. Address 2 is the counter. Address 3 is the limit. Read data appears on the clock after a read strobe. Unused status bits read 0.
- R3: The clock select works as follows. Code 0 stops the counter. Codes 1 to 7 advance it once every 2, 8, 32, 128, 512, 2048 or 4096 clocks respectively.
- R4: On a counter tick with the counter equal to the limit, the counter goes to 0 instead of incrementing. Successive matches are therefore (divisor × (limit+1)) clocks apart.
- R5: A match sets the flag. Writing 0 to bit 7 clears the flag only after the flag was read as 1. A write without that read leaves the flag set. A match in the same cycle as a clear wins.
- R6: When the enable bit is 1, the refresh request goes high for exactly one clock, on the clock after a match. When the enable bit is 0, no request is issued.
- R7: The first match after reset, or after either standby ends, sets the flag but issues no request.
- R8: The sleep input has no effect on counting, flags or requests.
- R9: During software standby the following holds:
  - The counter and prescaler stay at 0 and no requests occur.
  - Control, limit and clock select keep their values.
  - Register writes are ignored.
- R10: During hardware standby the following holds:
  - No counting or requests occur.
  - Every register returns to its reset value.
  - Reads return 0 and writes are ignored.
- R11: Software can write the counter, and a stopped counter keeps the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Sleep mode indication (no effect) |
| sw_stby_i | input | 1 | Software standby: clear counter, keep setup |
| hw_stby_i | input | 1 | Hardware standby: block inert, registers reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid one clock after reg_rd |
| rfsh_req_o | output | 1 | One-clock refresh request to the sequencer |

## Verification
A vector table runs the timer with four combinations of prescaler code, limit and enable. The measured spacing between pulses separates a wrong divisor tap from an off-by-one in the wrap. Comparing the pulse count with the number of flag sets separates correct first-match suppression from a missing or extra request. A disabled case shows that the enable gates only the request, not the flag. Directed runs follow for three cases:

- Sleep, which must look identical to normal running.
- Software standby, which must zero the counter and keep the setup.
- Hardware standby, which must wipe the setup.

Directed runs also cover flag-clear ordering and writes to a stopped counter.

// File: rtl/rfsh_tmr_pkg.sv
package rfsh_tmr_pkg;
  localparam int CSEL_W = 3;
  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_CSR = 2'd1;
  localparam logic [1:0] A_CNT = 2'd2;
  localparam logic [1:0] A_LIM = 2'd3;
  localparam int FLAG_BIT = 7;
  localparam int SEL_LSB  = 3;

  // number of low prescaler bits that must be all ones for a tick
  function automatic int unsigned sel_shift(int unsigned code);
    case (code)
      1: return 1;
      2: return 3;
      3: return 5;
      4: return 7;
      5: return 9;
      6: return 11;
      7: return 12;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler
  import rfsh_tmr_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [CSEL_W-1:0] sel,
  output logic              tick
);
  localparam int NSEL = 1 << CSEL_W;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_mask
    localparam int unsigned SH = sel_shift(g);
    assign mask[g] = {PRE_W{1'b1}} >> (PRE_W - SH);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) pre <= '0;
    else            pre <= pre + 1'b1;
  end

  assign tick = !clr && (sel != '0) && ((pre & mask[sel]) == mask[sel]);
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_clr,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] limit,
  output logic [DW-1:0] cnt,
  output logic          match
);
  assign match = tick && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || hold_clr) cnt <= '0;
    else if (wr_en)      cnt <= wr_data;
    else if (match)      cnt <= '0;
    else if (tick)       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rt_regs.sv
module rt_regs
  import rfsh_tmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freeze,
  input  logic              wipe,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  input  logic              match,
  input  logic [DW-1:0]     cnt,
  output logic [DW-1:0]     rdata,
  output logic              en,
  output logic [CSEL_W-1:0] sel,
  output logic [DW-1:0]     limit,
  output logic              flag,
  output logic              cnt_we
);
  logic wr_ok, armed, clr_ok;

  assign wr_ok  = wr && !freeze && !wipe;
  assign cnt_we = wr_ok && (addr == A_CNT);
  assign clr_ok = wr_ok && (addr == A_CSR) && !wdata[FLAG_BIT] && armed && !match;

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      en    <= 1'b0;
      sel   <= '0;
      limit <= '1;
      flag  <= 1'b0;
      armed <= 1'b0;
      rdata <= '0;
    end else begin
      if (match)       flag <= 1'b1;
      else if (clr_ok) flag <= 1'b0;

      if (clr_ok)                                armed <= 1'b0;
      else if (rd && addr == A_CSR && flag)      armed <= 1'b1;

      if (wr_ok) begin
        case (addr)
          A_CTL:   en    <= wdata[0];
          A_CSR:   sel   <= wdata[SEL_LSB +: CSEL_W];
          A_LIM:   limit <= wdata;
          default: ;
        endcase
      end

      if (rd) begin
        rdata <= '0;
        case (addr)
          A_CTL: rdata[0] <= en;
          A_CSR: begin
            rdata[FLAG_BIT]           <= flag;
            rdata[SEL_LSB +: CSEL_W]  <= sel;
          end
          A_CNT: rdata <= cnt;
          default: rdata <= limit;
        endcase
      end
    end
  end
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import rfsh_tmr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PRE_W = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_i,
  input  logic          sw_stby_i,
  input  logic          hw_stby_i,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          rfsh_req_o
);
  logic              hold;
  logic              tick, match, en, flag, cnt_we, first_pend;
  logic [CSEL_W-1:0] sel;
  logic [DW-1:0]     cnt, limit;
  logic              unused_sleep;

  // sleep leaves the timer running exactly as normal
  assign unused_sleep = sleep_i ^ flag;
  assign hold = sw_stby_i || hw_stby_i;

  rt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(hold), .sel(sel), .tick(tick)
  );

  rt_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .hold_clr(hold), .tick(tick),
    .wr_en(cnt_we), .wr_data(reg_wdata), .limit(limit),
    .cnt(cnt), .match(match)
  );

  rt_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .freeze(sw_stby_i), .wipe(hw_stby_i),
    .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .wdata(reg_wdata),
    .match(match), .cnt(cnt), .rdata(reg_rdata), .en(en), .sel(sel),
    .limit(limit), .flag(flag), .cnt_we(cnt_we)
  );

  always_ff @(posedge clk) begin
    if (rst || hw_stby_i) begin
      rfsh_req_o <= 1'b0;
      first_pend <= 1'b1;
    end else begin
      rfsh_req_o <= match && en && !first_pend;
      if (sw_stby_i)  first_pend <= 1'b1;
      else if (match) first_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/rfsh_tmr_chk.sv
module rfsh_tmr_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sw_stby_i,
  input logic          hw_stby_i,
  input logic          rfsh_req_o,
  input logic          match,
  input logic          en,
  input logic          first_pend,
  input logic          cnt_we,
  input logic [2:0]    sel,
  input logic [DW-1:0] cnt
);
  p_req_single_r6: assert property (@(posedge clk) disable iff (rst)
    rfsh_req_o |=> !rfsh_req_o);

  p_req_cause_r6: assert property (@(posedge clk) disable iff (rst)
    rfsh_req_o |-> ($past(match) && $past(en)));

  p_first_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (match && first_pend) |=> !rfsh_req_o);

  p_sw_zero_r9: assert property (@(posedge clk) disable iff (rst)
    sw_stby_i |=> (cnt == '0));

  p_hw_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    hw_stby_i |=> !rfsh_req_o);

  p_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd0 && !cnt_we && !sw_stby_i && !hw_stby_i) |=> $stable(cnt));

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (match && !cnt_we && !sw_stby_i && !hw_stby_i) |=> (cnt == '0));
endmodule

bind refresh_timer rfsh_tmr_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .sw_stby_i(sw_stby_i), .hw_stby_i(hw_stby_i),
  .rfsh_req_o(rfsh_req_o), .match(match), .en(en), .first_pend(first_pend),
  .cnt_we(cnt_we), .sel(sel), .cnt(cnt)
);

// File: tb/refresh_timer_tb.sv
module refresh_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_i = 1'b0, sw_stby_i = 1'b0, hw_stby_i = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       rfsh_req_o;

  int errors = 0, checks = 0;
  int npulse = 0, cyc = 0, t_last = 0, t_prev = 0;

  always #5 clk = ~clk;

  refresh_timer u_dut (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .sw_stby_i(sw_stby_i),
    .hw_stby_i(hw_stby_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rfsh_req_o(rfsh_req_o)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rfsh_req_o) begin
      npulse <= npulse + 1;
      t_prev <= t_last;
      t_last <= cyc;
    end
  end

  // {code[3], limit[8], enable[1], expected spacing[8]}
  localparam logic [19:0] VEC [4] = '{
    {3'd1, 8'd20, 1'b1, 8'd42},
    {3'd2, 8'd5,  1'b1, 8'd48},
    {3'd3, 8'd1,  1'b1, 8'd64},
    {3'd1, 8'd9,  1'b0, 8'd20}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic setup(logic [2:0] code, logic [7:0] lim, logic ena);
    wr_reg(2'd3, lim);
    wr_reg(2'd0, {7'd0, ena});
    wr_reg(2'd1, {2'b00, code, 3'b000});
  endtask

  // poll the flag until it has been seen n times, clearing it each time
  task automatic count_flags(logic [2:0] code, int n);
    logic [7:0] d;
    int seen = 0;
    while (seen < n) begin
      rd_reg(2'd1, d);
      if (d[7]) begin
        seen++;
        wr_reg(2'd1, {2'b00, code, 3'b000});
      end
    end
  endtask

  initial begin
    logic [7:0] d;
    int base;
    do_reset();

    // R1 / R2 reset values through the register map
    rd_reg(2'd0, d); check("R1 ctl", d, 8'h00);
    rd_reg(2'd1, d); check("R1 status", d, 8'h00);
    rd_reg(2'd2, d); check("R1 counter", d, 8'h00);
    rd_reg(2'd3, d); check("R2 limit", d, 8'hFF);
    check("R1 request", rfsh_req_o, 0);

    // table: R3 R4 R6 R7
    for (int i = 0; i < 4; i++) begin
      logic [2:0] code; logic [7:0] lim, per; logic ena;
      {code, lim, ena, per} = VEC[i];
      do_reset();
      setup(code, lim, ena);
      base = npulse;
      count_flags(code, 4);
      check(ena ? "R7 pulses=flags-1" : "R6 disabled no pulse",
            npulse - base, ena ? 3 : 0);
      if (ena) check("R4 R3 spacing", t_last - t_prev, per);
    end

    // R8 sleep has no effect
    do_reset();
    sleep_i = 1'b1;
    setup(3'd1, 8'd20, 1'b1);
    base = npulse;
    count_flags(3'd1, 4);
    check("R8 sleep pulses", npulse - base, 3);
    check("R8 sleep spacing", t_last - t_prev, 42);
    sleep_i = 1'b0;

    // R9 software standby
    count_flags(3'd1, 1);
    @(negedge clk); sw_stby_i = 1'b1;
    base = npulse;
    repeat (60) @(negedge clk);
    check("R9 no pulse in standby", npulse - base, 0);
    wr_reg(2'd3, 8'd7);
    rd_reg(2'd2, d); check("R9 counter zero", d, 0);
    rd_reg(2'd3, d); check("R9 limit kept", d, 20);
    rd_reg(2'd1, d); check("R9 select kept", d[5:3], 1);
    rd_reg(2'd0, d); check("R9 enable kept", d, 1);
    @(negedge clk); sw_stby_i = 1'b0;
    base = npulse;
    count_flags(3'd1, 3);
    check("R7 after sw standby", npulse - base, 2);

    // R10 hardware standby
    @(negedge clk); hw_stby_i = 1'b1;
    base = npulse;
    wr_reg(2'd3, 8'd5);
    rd_reg(2'd3, d); check("R10 read zero", d, 0);
    repeat (80) @(negedge clk);
    check("R10 no pulse", npulse - base, 0);
    @(negedge clk); hw_stby_i = 1'b0;
    rd_reg(2'd3, d); check("R10 limit reset", d, 8'hFF);
    rd_reg(2'd0, d); check("R10 ctl reset", d, 0);
    setup(3'd1, 8'd9, 1'b1);
    base = npulse;
    count_flags(3'd1, 3);
    check("R7 after hw standby", npulse - base, 2);

    // R5 flag clear ordering
    do_reset();
    setup(3'd1, 8'd3, 1'b0);
    repeat (20) @(negedge clk);
    wr_reg(2'd1, 8'h00);           // stops counter, no prior read
    rd_reg(2'd1, d); check("R5 flag sticky without read", d[7], 1);
    wr_reg(2'd1, 8'h00);
    rd_reg(2'd1, d); check("R5 flag cleared after read", d[7], 0);

    // R11 counter write, R3 code 0 stops
    wr_reg(2'd2, 8'h33);
    repeat (10) @(negedge clk);
    rd_reg(2'd2, d); check("R11 R3 counter held", d, 8'h33);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule